// File: doc/BRIEF.md
# Dual-Clock Long-Word FIFO with Whole-Word Almost-Full Flag

This block is a first-in first-out buffer that carries 36-bit long words from a write clock domain to an unrelated read clock domain. The depth is a parameter with five legal values: 256, 512, 1024, 4096 or 16384 long words. Each side keeps a binary pointer and a Gray copy of it. The Gray copy crosses to the other side through two flip-flops, so each side sees the other's position in its own clock.

The read side can hand out a whole long word, one 18-bit half or one 9-bit quarter per read. The width is chosen by a mode input. The block takes that input once, on the first read clock after reset. A narrow read always starts with the most significant portion, and the narrow value sits in the low bits of the output. A long word stays in the buffer until its last portion is read. Only that read advances the read pointer.

The write side has a full flag and an active-low almost-full flag. Both are computed from the whole long words the write side can see. The almost-full threshold sits a programmable number of long words below the depth. Output data is registered: a word that has reached the output register counts as read.

Top module: `lw_async_fifo`

## Requirements
- R1: While reset is held and just after it is released, empty_o is 1, full_o is 0, afull_no is 1 and rdata_o is 0.
- R2: With rmode_i = 2'b00 (long), each accepted read loads the oldest unread long word into rdata_o[35:0] on that read clock edge, in write order.
- R3: With rmode_i = 2'b01 (word), a long word takes two reads. The first gives bits [35:18] and the second gives bits [17:0]. Both appear in rdata_o[17:0], and rdata_o[35:18] is 0.
- R4: With rmode_i = 2'b10 (byte), a long word takes four reads, giving bits [35:27], [26:18], [17:9] and [8:0] in that order. Each appears in rdata_o[8:0], and the other bits are 0.
- R5: rmode_i is captured on the first read clock edge after reset release. Later changes have no effect until the next reset.
- R6: A write is stored only on a write clock edge where wcs_i and wen_i are both 1 and full_o is 0. Any other write attempt, including one made while full, is dropped and never shows up in the read data.
- R7: A read request while empty_o is 1 is ignored: rdata_o holds its value and the read position does not move.
- R8: full_o is 1 exactly when the write side sees DEPTH unread long words.
- R9: afull_no goes to 0 right after the write edge that brings the write side's count to DEPTH-AF_OFFSET. It stays 1 while the count is DEPTH-AF_OFFSET-1 or less.
- R10: After the read that frees a long word and brings the count to DEPTH-AF_OFFSET-1, afull_no returns to 1 on the second write clock edge after that read. If the two clock edges fall very close together, this can slip to the third.
- R11: In word or byte mode, a read that is not the last portion of a long word frees nothing: afull_no and full_o do not change.
- R12: empty_o is 1 when the read side sees no unread long word. After a write into an empty buffer, empty_o falls on the second or third read clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wcs_i | input | 1 | Write chip select |
| wen_i | input | 1 | Write enable |
| wdata_i | input | 36 | Long word to write |
| full_o | output | 1 | Buffer holds DEPTH long words (write domain) |
| afull_no | output | 1 | Active-low almost-full flag (write domain) |
| rmode_i | input | 2 | Read width: 00 long, 01 word, 10 byte |
| ren_i | input | 1 | Read enable |
| rdata_o | output | 36 | Registered read data, narrow portions in the low bits |
| empty_o | output | 1 | No unread long word (read domain) |

## Verification
The riskiest overlap is a write and a freeing read landing together while the buffer sits near its threshold or completely full. The write side then judges its flags from a read position that lags behind. A mixed phase drives writes every other write clock against slower reads on a clock with an unrelated period, so the buffer fills, refuses writes and frees space in interleaved cycles. A queue model judges every read value. On every clock the model checks that the flags never claim less occupancy than the true count allows.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  localparam int LW_W   = 36;
  localparam int HALF_W = LW_W / 2;
  localparam int UNIT_W = LW_W / 4;

  typedef enum logic [1:0] {
    RD_LONG = 2'b00,
    RD_WORD = 2'b01,
    RD_BYTE = 2'b10
  } rd_mode_e;
endpackage

// File: rtl/lwf_mem.sv
module lwf_mem #(
  parameter  int DEPTH = 256,
  parameter  int W     = 36,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lwf_sync.sv
module lwf_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lwf_g2b.sv
module lwf_g2b #(
  parameter int W = 9
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/lwf_wr_ctl.sv
module lwf_wr_ctl #(
  parameter  int DEPTH     = 256,
  parameter  int AF_OFFSET = 8,
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wcs_i,
  input  logic          wen_i,
  input  logic [PW-1:0] rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          afull_no
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] AF_CNT   = PW'(DEPTH - AF_OFFSET);

  logic [PW-1:0] wbin_q, wbin_nxt, wgray_q, rbin_s, count;

  lwf_g2b #(.W(PW)) u_g2b (
    .gray_i (rgray_sync_i),
    .bin_o  (rbin_s)
  );

  // occupancy in whole long words as seen from the write side
  assign count    = wbin_q - rbin_s;
  assign full_o   = (count == FULL_CNT);
  assign afull_no = ~(count >= AF_CNT);
  assign we_o     = wcs_i & wen_i & ~full_o;
  assign wbin_nxt = wbin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
endmodule

// File: rtl/lwf_rd_ctl.sv
module lwf_rd_ctl
  import lwf_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      rmode_i,
  input  logic            ren_i,
  input  logic [PW-1:0]   wgray_sync_i,
  input  logic [LW_W-1:0] mem_rdata_i,
  output logic [AW-1:0]   raddr_o,
  output logic [PW-1:0]   rgray_o,
  output logic            empty_o,
  output logic [LW_W-1:0] rdata_o
);
  rd_mode_e        mode_q, mode_dec;
  logic            armed_q;
  logic [1:0]      unit_q;
  logic [PW-1:0]   rbin_q, rbin_nxt, rgray_q;
  logic [LW_W-1:0] rdata_q, slice;
  logic            last_unit, rd_fire;

  always_comb begin
    case (rmode_i)
      2'b01:   mode_dec = RD_WORD;
      2'b10:   mode_dec = RD_BYTE;
      default: mode_dec = RD_LONG;
    endcase
  end

  assign empty_o = (rgray_q == wgray_sync_i);
  assign rd_fire = armed_q & ren_i & ~empty_o;

  always_comb begin
    case (mode_q)
      RD_WORD: last_unit = unit_q[0];
      RD_BYTE: last_unit = (unit_q == 2'd3);
      default: last_unit = 1'b1;
    endcase
  end

  // most significant portion first, narrow data right-aligned
  always_comb begin
    case (mode_q)
      RD_WORD: slice = unit_q[0] ? {{HALF_W{1'b0}}, mem_rdata_i[HALF_W-1:0]}
                                 : {{HALF_W{1'b0}}, mem_rdata_i[LW_W-1:HALF_W]};
      RD_BYTE: begin
        case (unit_q)
          2'd0:    slice = {{(LW_W-UNIT_W){1'b0}}, mem_rdata_i[4*UNIT_W-1:3*UNIT_W]};
          2'd1:    slice = {{(LW_W-UNIT_W){1'b0}}, mem_rdata_i[3*UNIT_W-1:2*UNIT_W]};
          2'd2:    slice = {{(LW_W-UNIT_W){1'b0}}, mem_rdata_i[2*UNIT_W-1:UNIT_W]};
          default: slice = {{(LW_W-UNIT_W){1'b0}}, mem_rdata_i[UNIT_W-1:0]};
        endcase
      end
      default: slice = mem_rdata_i;
    endcase
  end

  assign rbin_nxt = rbin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= RD_LONG;
      armed_q <= 1'b0;
      unit_q  <= '0;
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
    end else begin
      if (!armed_q) begin
        mode_q  <= mode_dec;
        armed_q <= 1'b1;
      end
      if (rd_fire) begin
        rdata_q <= slice;
        if (last_unit) begin
          unit_q  <= '0;
          rbin_q  <= rbin_nxt;
          rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
        end else begin
          unit_q  <= unit_q + 2'd1;
        end
      end
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/lw_async_fifo.sv
module lw_async_fifo
  import lwf_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int AF_OFFSET = 8
) (
  input  logic            wclk_i,
  input  logic            rclk_i,
  input  logic            rst_ni,
  input  logic            wcs_i,
  input  logic            wen_i,
  input  logic [LW_W-1:0] wdata_i,
  output logic            full_o,
  output logic            afull_no,
  input  logic [1:0]      rmode_i,
  input  logic            ren_i,
  output logic [LW_W-1:0] rdata_o,
  output logic            empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic            wr_we;
  logic [AW-1:0]   wr_addr, rd_addr;
  logic [PW-1:0]   wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [LW_W-1:0] mem_rdata;

  lwf_mem #(.DEPTH(DEPTH), .W(LW_W)) u_mem (
    .clk_i   (wclk_i),
    .we_i    (wr_we),
    .waddr_i (wr_addr),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (mem_rdata)
  );

  lwf_wr_ctl #(.DEPTH(DEPTH), .AF_OFFSET(AF_OFFSET)) u_wr (
    .clk_i        (wclk_i),
    .rst_ni       (rst_ni),
    .wcs_i        (wcs_i),
    .wen_i        (wen_i),
    .rgray_sync_i (rd_gray_s),
    .we_o         (wr_we),
    .waddr_o      (wr_addr),
    .wgray_o      (wr_gray),
    .full_o       (full_o),
    .afull_no     (afull_no)
  );

  lwf_sync #(.W(PW)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rd_gray),
    .q_o    (rd_gray_s)
  );

  lwf_sync #(.W(PW)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wr_gray),
    .q_o    (wr_gray_s)
  );

  lwf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk_i        (rclk_i),
    .rst_ni       (rst_ni),
    .rmode_i      (rmode_i),
    .ren_i        (ren_i),
    .wgray_sync_i (wr_gray_s),
    .mem_rdata_i  (mem_rdata),
    .raddr_o      (rd_addr),
    .rgray_o      (rd_gray),
    .empty_o      (empty_o),
    .rdata_o      (rdata_o)
  );
endmodule

// File: rtl/lwf_chk.sv
module lwf_chk #(
  parameter  int DEPTH = 256,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wcs_i,
  input logic          wen_i,
  input logic          full_o,
  input logic          afull_no,
  input logic          ren_i,
  input logic          empty_o,
  input logic [35:0]   rdata_o,
  input logic [PW-1:0] wgray_i,
  input logic [PW-1:0] rgray_i
);
  // R8
  full_implies_afull_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> !afull_no);

  // R8
  full_rise_on_write_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(wcs_i && wen_i));

  // R6
  no_write_when_full_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && wcs_i && wen_i) |=> $stable(wgray_i));

  // R9
  afull_fall_on_write_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $fell(afull_no) |-> $past(wcs_i && wen_i));

  // R7
  no_read_when_empty_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && ren_i) |=> ($stable(rdata_o) && $stable(rgray_i)));

  // R12
  empty_rise_on_read_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(ren_i));
endmodule

bind lw_async_fifo lwf_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .wcs_i    (wcs_i),
  .wen_i    (wen_i),
  .full_o   (full_o),
  .afull_no (afull_no),
  .ren_i    (ren_i),
  .empty_o  (empty_o),
  .rdata_o  (rdata_o),
  .wgray_i  (wr_gray),
  .rgray_i  (rd_gray)
);

// File: tb/lw_async_fifo_bench.sv
module lw_async_fifo_bench;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int D = 256;
  localparam int Y = 8;

  logic        wclk, rclk, rst_n;
  logic        wcs, wen, ren;
  logic [35:0] wdata, rdata;
  logic [1:0]  rmode;
  logic        full, afull_n, empty;

  lw_async_fifo #(.DEPTH(D), .AF_OFFSET(Y)) u_lw_async_fifo (
    .wclk_i   (wclk),
    .rclk_i   (rclk),
    .rst_ni   (rst_n),
    .wcs_i    (wcs),
    .wen_i    (wen),
    .wdata_i  (wdata),
    .full_o   (full),
    .afull_no (afull_n),
    .rmode_i  (rmode),
    .ren_i    (ren),
    .rdata_o  (rdata),
    .empty_o  (empty)
  );

  int checks = 0;
  int fails = 0;
  logic [35:0] lw_q[$];
  int munit = 0;
  logic [1:0] mode_m = 2'b00;
  bit inv_en = 0;
  int wedge_cnt = 0, redge_cnt = 0;
  int wedge_at_rd = 0, redge_at_wr = 0;
  bit wr_done = 0;

  initial begin
    wclk = 0;
    forever #(WCLK_PERIOD/2) wclk = ~wclk;
  end
  initial begin
    rclk = 0;
    #1;
    forever #(RCLK_PERIOD/2) rclk = ~rclk;
  end

  always @(posedge wclk) wedge_cnt <= wedge_cnt + 1;
  always @(posedge rclk) redge_cnt <= redge_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int units(input logic [1:0] m);
    return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] exp_unit(input logic [35:0] lw, input logic [1:0] m, input int u);
    case (m)
      2'b01:   return (u == 0) ? {18'b0, lw[35:18]} : {18'b0, lw[17:0]};
      2'b10:   return {27'b0, 9'(lw >> (9*(3-u)))};
      default: return lw;
    endcase
  endfunction

  function automatic logic [35:0] pat(input int i, input int tag);
    return {4'(tag), 32'(i * 32'h01000193 + 7)};
  endfunction

  // per-clock model comparison: flags never claim less than the true occupancy
  always begin
    @(negedge wclk); #1;
    if (inv_en) begin
      chk(!(lw_q.size() >= D-Y) || !afull_n, "R9", "afull vs model count", 36'(afull_n), 36'(0));
      chk(!(lw_q.size() == D) || full, "R8", "full vs model count", 36'(full), 36'(1));
    end
  end
  always begin
    @(negedge rclk); #1;
    if (inv_en) chk(lw_q.size() != 0 || empty, "R12", "empty vs model count", 36'(empty), 36'(1));
  end

  task automatic do_reset(input logic [1:0] m);
    inv_en = 0;
    @(negedge wclk);
    rst_n = 0; rmode = m; wcs = 0; wen = 0; ren = 0; wdata = '0;
    repeat (3) @(negedge wclk);
    lw_q.delete(); munit = 0; mode_m = m;
    #3 rst_n = 1;
    repeat (4) @(negedge rclk);
    inv_en = 1;
  endtask

  task automatic wr_lw(input logic [35:0] d, input bit cs, input bit en);
    bit acc;
    @(negedge wclk);
    wcs = cs; wen = en; wdata = d;
    acc = cs && en && !full;
    @(posedge wclk);
    redge_at_wr = redge_cnt;
    if (acc) lw_q.push_back(d);
    @(negedge wclk);
    wcs = 0; wen = 0;
  endtask

  task automatic rd_unit(output bit did, output bit freed);
    logic [35:0] e;
    string req;
    did = 0; freed = 0;
    @(negedge rclk);
    if (empty) return;
    did = 1;
    ren = 1;
    @(posedge rclk);
    wedge_at_rd = wedge_cnt;
    e = exp_unit(lw_q[0], mode_m, munit);
    munit++;
    if (munit == units(mode_m)) begin
      void'(lw_q.pop_front());
      munit = 0;
      freed = 1;
    end
    @(negedge rclk);
    ren = 0;
    req = (mode_m == 2'b01) ? "R3" : (mode_m == 2'b10) ? "R4" : "R2";
    chk(rdata === e, req, "read data order", rdata, e);
  endtask

  task automatic rd_one(output bit freed);
    bit did;
    int g = 0;
    did = 0; freed = 0;
    while (!did && g < 50) begin rd_unit(did, freed); g++; end
  endtask

  task automatic drain();
    bit did, fr;
    int g = 0;
    while (lw_q.size() > 0 && g < 100000) begin rd_unit(did, fr); g++; end
  endtask

  task automatic measure_release(input string what);
    int g = 0;
    int n;
    while (!afull_n && g < 10) begin @(posedge wclk); #1; g++; end
    n = wedge_cnt - wedge_at_rd;
    chk(n >= 2 && n <= 3, "R10", what, 36'(n), 36'(2));
  endtask

  task automatic check_hold(input string req, input string what);
    repeat (6) @(negedge wclk);
    chk(afull_n == 0, req, what, 36'(afull_n), 36'(0));
    chk(full == 0, req, {what, " full"}, 36'(full), 36'(0));
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit fr;
    logic [35:0] prev;
    int n, g;
    rst_n = 0; wcs = 0; wen = 0; ren = 0; wdata = '0; rmode = 2'b00;

    // ---- long mode
    do_reset(2'b00);
    chk(empty == 1, "R1", "reset empty", 36'(empty), 36'(1));
    chk(full == 0, "R1", "reset full", 36'(full), 36'(0));
    chk(afull_n == 1, "R1", "reset afull", 36'(afull_n), 36'(1));
    chk(rdata == 0, "R1", "reset rdata", rdata, 36'(0));

    wr_lw(pat(0, 1), 1, 1);
    g = 0;
    while (empty && g < 10) begin @(posedge rclk); #1; g++; end
    n = redge_cnt - redge_at_wr;
    chk(n >= 2 && n <= 3, "R12", "empty fall latency", 36'(n), 36'(2));
    wr_lw(pat(1, 1), 0, 1);  // R6: no chip select
    wr_lw(pat(2, 1), 1, 0);  // R6: no enable
    for (int i = 3; i < 7; i++) wr_lw(pat(i, 1), 1, 1);
    chk(lw_q.size() == 5, "R6", "accepted writes", 36'(lw_q.size()), 36'(5));
    repeat (4) @(negedge rclk);
    drain();
    repeat (4) @(negedge rclk);
    chk(empty == 1, "R12", "empty after drain", 36'(empty), 36'(1));

    // R7: read while empty
    prev = rdata;
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
    chk(rdata === prev, "R7", "rdata held on empty read", rdata, prev);
    wr_lw(pat(50, 2), 1, 1);
    repeat (5) @(negedge rclk);
    rd_one(fr);  // R7: pointer unmoved, the new word comes out next

    // R9 threshold and R8 full
    for (int i = 0; i < D-Y-1; i++) wr_lw(pat(i, 3), 1, 1);
    repeat (4) @(negedge wclk);
    chk(afull_n == 1, "R9", "afull high at D-Y-1", 36'(afull_n), 36'(1));
    wr_lw(pat(D-Y-1, 3), 1, 1);
    chk(afull_n == 0, "R9", "afull low at D-Y", 36'(afull_n), 36'(0));
    for (int i = D-Y; i < D-1; i++) wr_lw(pat(i, 3), 1, 1);
    chk(full == 0, "R8", "not full at D-1", 36'(full), 36'(0));
    wr_lw(pat(D-1, 3), 1, 1);
    chk(full == 1, "R8", "full at D", 36'(full), 36'(1));
    wr_lw(36'hBAD_BAD_BAD, 1, 1);  // R6: dropped while full
    chk(lw_q.size() == D, "R6", "write while full dropped", 36'(lw_q.size()), 36'(D));

    for (int i = 0; i < Y; i++) rd_one(fr);
    repeat (6) @(negedge wclk);
    chk(afull_n == 0, "R9", "afull held at D-Y", 36'(afull_n), 36'(0));
    rd_one(fr);
    measure_release("long mode release");
    drain();

    // ---- byte mode, later mode change ignored (R5)
    do_reset(2'b10);
    rmode = 2'b00;
    for (int i = 0; i < D-Y; i++) wr_lw(pat(i, 4), 1, 1);
    chk(afull_n == 0, "R9", "byte mode afull at D-Y", 36'(afull_n), 36'(0));
    repeat (4) @(negedge rclk);
    for (int k = 0; k < 3; k++) begin
      rd_one(fr);
      check_hold("R11", "byte partial read frees nothing");
    end
    rd_one(fr);
    measure_release("byte mode release");
    for (int k = 0; k < 8; k++) rd_one(fr);
    chk(munit == 0 && mode_m == 2'b10, "R5", "byte mode kept after rmode change", 36'(munit), 36'(0));

    // ---- word mode
    do_reset(2'b01);
    for (int i = 0; i < D-Y; i++) wr_lw(pat(i, 6), 1, 1);
    repeat (4) @(negedge rclk);
    rd_one(fr);
    check_hold("R11", "word partial read frees nothing");
    rd_one(fr);
    measure_release("word mode release");
    for (int k = 0; k < 6; k++) rd_one(fr);

    // ---- overlapping writes and reads near full
    do_reset(2'b00);
    wr_done = 0;
    fork
      begin
        for (int i = 0; i < 400; i++) wr_lw(pat(i, 7), 1, 1);
        wr_done = 1;
      end
      begin
        bit did, f2;
        int gg = 0;
        repeat (300) @(negedge wclk);
        while (!(wr_done && lw_q.size() == 0) && gg < 100000) begin
          rd_unit(did, f2);
          gg++;
        end
      end
    join
    repeat (4) @(negedge rclk);
    chk(empty == 1, "R12", "empty after overlap phase", 36'(empty), 36'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule